// File: doc/BRIEF.md
# Display pixel clock divider

This block turns one of four source clock strobes into two system-clock enable pulse trains: a panel pixel clock enable and a serial-link bit clock enable. A single 32-bit control word sets the source, an integer pixel divisor with a 12-bit fractional extension, a small bit-clock divisor with bypass and off codes, and a hard gate on the pixel output.

Each source is given as a strobe input that is high for one system clock cycle for every source clock edge. The pixel divider counts strobes of the selected source and emits one output pulse per period. A 12-bit fraction is added to an accumulator at the end of every period. Each carry out of that accumulator lengthens the following period by one source cycle, so over time the divide ratio is N + F/4096. A control word on the same source is applied only where a pixel period ends, so no runt period is produced. A change of source is applied at once and restarts every counter.

Top module: `pclk_gen`

## Requirements
- R1: After reset both outputs are low and the active word is 0x40001102. This is source 1, pixel divide 2, bit clock bypass, zero fraction and output enabled.
- R2: Bits 31:30 pick the counted strobe: 0 is src_stb_i[0] (bus clock), 1 and 2 are src_stb_i[1] and src_stb_i[2] (display clocks), and 3 is src_stb_i[3] (HDMI PLL). Strobes on the other inputs have no effect on either output.
- R3: Bits 7:0 give the integer pixel divisor N. pix_en_o pulses for one cycle, one cycle after every Nth selected strobe. Codes 0 and 1 act as 2.
- R4: Bits 27:16 give a fraction F. F is added modulo 4096 at the end of each pixel period. A carry makes the next period N+1 strobes long.
- R5: When bit 28 is set, pix_en_o stays low. The pixel counters keep running.
- R6: Bits 11:8 give the bit clock code M. For M from 2 to 15, mipi_en_o pulses one cycle after every Mth selected strobe.
- R7: With M = 1, mipi_en_o follows every selected strobe one cycle later. With M = 0, mipi_en_o stays low.
- R8: A new word with the same source as the active word waits. It is applied in the cycle of the strobe that ends the current pixel period, and at that point it clears the counters and the accumulator.
- R9: A new word with a different source is applied at once, and it clears all counters and the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Requested control word |
| src_stb_i | input | 4 | One strobe per source clock edge, one bit per source |
| pix_en_o | output | 1 | Pixel clock enable pulse |
| mipi_en_o | output | 1 | Bit clock enable pulse |

## Verification
A wrong pixel count, a wrong stretch bit or a wrong accumulator shifts the next pix_en_o pulse by one or more strobes. That error appears within one pixel period, or within two periods when the stretch is involved. A control word applied at the wrong moment moves the very next pulse, and a mis-selected source shows up on the first foreign strobe. The bench therefore compares both outputs on every cycle against a reference model of the requirements. It adds pulse counts over windows whose expected values are computed by hand.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int INT_W   = 8;
  localparam int FRAC_W  = 12;
  localparam int MIPI_W  = 4;
  localparam int CFG_W   = 32;
  localparam int RSV_W   = CFG_W - SRC_W - 2 - FRAC_W - MIPI_W - INT_W;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic              rsv_hi;
    logic              pix_off;
    logic [FRAC_W-1:0] frac;
    logic [RSV_W-1:0]  rsv_mid;
    logic [MIPI_W-1:0] mipi_div;
    logic [INT_W-1:0]  pix_div;
  } pclk_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST = 32'h4000_1102;
endpackage

// File: rtl/pclk_cfg_ctrl.sv
module pclk_cfg_ctrl
  import pclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pclk_cfg_t cfg_i,
  input  logic      period_end_i,
  output pclk_cfg_t act_o,
  output logic      load_o
);
  pclk_cfg_t act_q;
  logic      src_chg;

  assign src_chg = cfg_i.src != act_q.src;
  assign load_o  = (cfg_i != act_q) && (src_chg || period_end_i);
  assign act_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= pclk_cfg_t'(CFG_RST);
    else if (load_o) act_q <= cfg_i;
  end

  // R8: active word only moves on a load
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(load_o));
  // R9: differing source is taken on the next edge
  a_r9_src_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.src != act_q.src) |=> (act_q == $past(cfg_i)));
endmodule

// File: rtl/pclk_pix_div.sv
module pclk_pix_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              restart_i,
  input  logic [INT_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              term_o
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic [CNT_W-1:0]  n_eff;
  logic [CNT_W-1:0]  last;
  logic [FRAC_W:0]   acc_sum;

  // codes below 2 clamp to 2
  assign n_eff   = (div_i < INT_W'(2)) ? CNT_W'(2) : {1'b0, div_i};
  assign last    = n_eff - CNT_W'(1) + CNT_W'(ext_q);
  assign term_o  = stb_i && (cnt_q == last);
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (term_o) begin
      cnt_q <= '0;
      acc_q <= acc_sum[FRAC_W-1:0];
      ext_q <= acc_sum[FRAC_W];
    end else if (stb_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: counter never passes the period end
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  // R4: stretch is only armed at a period end
  a_r4_ext_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_q) |-> $past(term_o));
endmodule

// File: rtl/pclk_mipi_div.sv
module pclk_mipi_div #(
  parameter int MIPI_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              restart_i,
  input  logic [MIPI_W-1:0] code_i,
  output logic              pulse_o
);
  typedef enum logic [1:0] {M_OFF, M_BYP, M_DIV} mode_e;

  mode_e             mode;
  logic [MIPI_W-1:0] cnt_q;
  logic              term;

  always_comb begin
    unique case (code_i)
      MIPI_W'(0): mode = M_OFF;
      MIPI_W'(1): mode = M_BYP;
      default:    mode = M_DIV;
    endcase
  end

  assign term = stb_i && (mode == M_DIV) && (cnt_q == code_i - MIPI_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= (mode == M_BYP) ? stb_i : term;
      if (restart_i || mode != M_DIV) cnt_q <= '0;
      else if (term)                  cnt_q <= '0;
      else if (stb_i)                 cnt_q <= cnt_q + MIPI_W'(1);
    end
  end

  // R7: off code keeps the output quiet
  a_r7_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode == M_OFF) |-> !pulse_o);
  // R6: divide counter stays below the code
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_DIV && $past(mode == M_DIV) && $stable(code_i)) |-> cnt_q < code_i);
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
  import pclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [NUM_SRC-1:0] src_stb_i,
  output logic             pix_en_o,
  output logic             mipi_en_o
);
  pclk_cfg_t act;
  logic      load;
  logic      sel_stb;
  logic      pix_term;

  assign sel_stb = src_stb_i[act.src];

  pclk_cfg_ctrl u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (pclk_cfg_t'(cfg_i)),
    .period_end_i (pix_term),
    .act_o        (act),
    .load_o       (load)
  );

  pclk_pix_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (sel_stb),
    .restart_i (load),
    .div_i     (act.pix_div),
    .frac_i    (act.frac),
    .term_o    (pix_term)
  );

  pclk_mipi_div #(.MIPI_W(MIPI_W)) u_mipi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (sel_stb),
    .restart_i (load),
    .code_i    (act.mipi_div),
    .pulse_o   (mipi_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_en_o <= 1'b0;
    else         pix_en_o <= pix_term && !act.pix_off;
  end

  // R2: pixel pulse follows a selected strobe
  a_r2_pix_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |-> $past(sel_stb));
  // R5: disabled word never yields a pulse
  a_r5_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |-> !$past(act.pix_off));
  // R3: divide of at least 2 forbids back-to-back pixel pulses
  a_r3_no_b2b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |=> !pix_en_o);
endmodule

// File: tb/sim_pclk_gen.sv
`timescale 1ns/1ps
module sim_pclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = 32'h4000_1102;
  logic [3:0]  stb = 4'h0;
  logic        pix, mipi;

  int vec = 0, miss = 0;
  bit checking = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .src_stb_i(stb),
    .pix_en_o(pix), .mipi_en_o(mipi)
  );

  // reference model built from the requirements
  logic [31:0] m_act;
  int          m_cnt, m_acc, m_mcnt;
  bit          m_ext;
  logic        e_pix, e_mipi;

  always @(posedge clk or negedge rst_n) begin : mdl
    int n, f, m, sum;
    logic s, t, ld, mt;
    if (!rst_n) begin
      m_act <= 32'h4000_1102; m_cnt <= 0; m_acc <= 0; m_mcnt <= 0;
      m_ext <= 1'b0; e_pix <= 1'b0; e_mipi <= 1'b0;
    end else begin
      s = stb[m_act[31:30]];
      n = int'(m_act[7:0]); if (n < 2) n = 2;
      f = int'(m_act[27:16]);
      m = int'(m_act[11:8]);
      t = s && (m_cnt == n - 1 + int'(m_ext));
      ld = (cfg != m_act) && ((cfg[31:30] != m_act[31:30]) || t);
      e_pix <= t && !m_act[28];
      mt = s && (m >= 2) && (m_mcnt == m - 1);
      e_mipi <= (m == 1) ? s : mt;
      sum = m_acc + f;
      if (ld) begin
        m_act <= cfg; m_cnt <= 0; m_acc <= 0; m_ext <= 1'b0; m_mcnt <= 0;
      end else begin
        if (t) begin
          m_cnt <= 0; m_acc <= sum % 4096; m_ext <= (sum >= 4096);
        end else if (s) m_cnt <= m_cnt + 1;
        if (m < 2 || mt) m_mcnt <= 0;
        else if (s) m_mcnt <= m_mcnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking) begin
      vec += 2;
      if (pix !== e_pix) begin
        miss++; $display("FAIL %s pix_en_o act=%0b exp=%0b t=%0t", cur_req, pix, e_pix, $time);
      end
      if (mipi !== e_mipi) begin
        miss++; $display("FAIL %s mipi_en_o act=%0b exp=%0b t=%0t", cur_req, mipi, e_mipi, $time);
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++; $display("FAIL %s count act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk); cfg = w; stb = 4'h0;
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(negedge clk); stb = 4'h0; end
  endtask

  task automatic burst(input logic [3:0] mask, input int k, output int pc, output int mc);
    pc = 0; mc = 0;
    for (int i = 0; i < k + 2; i++) begin
      @(negedge clk);
      pc += int'(pix); mc += int'(mipi);
      stb = (i < k) ? mask : 4'h0;
    end
  endtask

  // load w through a source change so it takes effect at once
  task automatic win(input logic [31:0] w, input logic [3:0] mask, input int k,
                     output int pc, output int mc);
    set_cfg(w ^ 32'h4000_0000); idle(2);
    set_cfg(w); idle(2);
    burst(mask, k, pc, mc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin : stim
    int pc, mc;
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pix", int'(pix), 0);
    chk("R1 reset mipi", int'(mipi), 0);
    checking = 1'b1;

    cur_req = "R1";
    burst(4'b0010, 40, pc, mc);
    chk("R1 default pix", pc, 20);
    chk("R1 default mipi", mc, 40);

    cur_req = "R3";
    win(32'h0000_0000, 4'b0001, 40, pc, mc);
    chk("R3 clamp pix", pc, 20);
    chk("R7 off mipi", mc, 0);

    cur_req = "R6";
    win(32'h8000_0505, 4'b0100, 40, pc, mc);
    chk("R3 div5 pix", pc, 8);
    chk("R6 div5 mipi", mc, 8);

    cur_req = "R4";
    win(32'hC800_0002, 4'b1000, 40, pc, mc);
    chk("R4 frac half pix", pc, 16);

    cur_req = "R5";
    win(32'h5000_0103, 4'b0010, 40, pc, mc);
    chk("R5 off pix", pc, 0);
    chk("R7 bypass mipi", mc, 40);

    cur_req = "R2";
    win(32'h4000_0102, 4'b1101, 40, pc, mc);
    chk("R2 foreign pix", pc, 0);
    chk("R2 foreign mipi", mc, 0);

    cur_req = "R8";
    win(32'h4000_000A, 4'b0010, 40, pc, mc);
    chk("R3 div10 pix", pc, 4);
    set_cfg(32'h4000_0002); idle(3);
    burst(4'b0010, 9, pc, mc);
    chk("R8 held pix", pc, 0);
    burst(4'b0010, 5, pc, mc);
    chk("R8 applied pix", pc, 3);

    cur_req = "R9";
    win(32'h4000_000A, 4'b0010, 5, pc, mc);
    chk("R9 mid pix", pc, 0);
    set_cfg(32'h8000_000A); idle(2);
    burst(4'b0100, 9, pc, mc);
    chk("R9 restart pix", pc, 0);
    burst(4'b0100, 1, pc, mc);
    chk("R9 restart end pix", pc, 1);

    cur_req = "R4 R8 random";
    for (int r = 0; r < 60; r++) begin
      w = 32'h0;
      w[31:30] = 2'($urandom % 4);
      w[28]    = ($urandom % 6) == 0;
      w[27:16] = 12'($urandom);
      w[11:8]  = 4'($urandom % 16);
      w[7:0]   = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 12);
      @(negedge clk); cfg = w;
      for (int c = 0; c < 40 + int'($urandom % 200); c++) begin
        @(negedge clk); stb = 4'($urandom);
      end
    end
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule